// File: doc/BRIEF.md
# Data-Ready Pulse Indicator

This block signals, on a general-purpose pin, that the sensor output register has just been refreshed. Each time the output-register logic raises a one-cycle update strobe, the block drives a single pulse on one of two pins. The pulse then returns to the idle level. Software sets up the block through a 16-bit control register written over a simple write port. The register holds an enable bit, a polarity bit and a pin-select bit.

The pulse lasts a fixed number of clock cycles, derived from the nominal update period. This keeps the duty cycle of the indicator waveform inside a 15–35 % band when updates arrive at the nominal rate. The pin that is not selected, and both pins while the function is off, have their output-enable low. Those pins are then free for general-purpose use.

Top module: `drdy_pulse_gen`

## Requirements
- R1: After reset the control register is 0x0000: both output-enables are low and both pin values are 0.
- R2: With control bit 2 at 0, the function is off. Both output-enables stay low and update strobes create no pulse. Control bits 15:3 have no effect.
- R3: Control bit 1 sets polarity. With 1 the pulse is high and the idle level is low. With 0 the pulse is low and the idle level is high.
- R4: Control bit 0 picks the pin. With 0 the pulse appears on pin A, and pin B has output-enable 0 and value 0. With 1 the pulse appears on pin B, and pin A has output-enable 0 and value 0.
- R5: With bit 2 at 1, a strobe sampled at a clock edge puts the selected pin at its active level from that edge on. The pin stays active for exactly PULSE_LEN cycles, then goes back to idle. PULSE_LEN is UPDATE_PERIOD/4, rounded down, with a minimum of 1.
- R6: With strobes every UPDATE_PERIOD cycles, the selected pin spends between 15 % and 35 % of the time at its active level.
- R7: A strobe that arrives while a pulse is active restarts the count. The pulse then ends PULSE_LEN cycles after the latest strobe.
- R8: A register write takes effect at the clock edge that samples it. A write that clears bit 2 also cancels any pulse in progress, so a later re-enable starts at the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_strobe | input | 1 | One-cycle strobe from the output-register logic, high when that register updates |
| ctrl_wr | input | 1 | Control register write enable |
| ctrl_wdata | input | CTRL_W | Control register write data |
| pin_a_out | output | 1 | Drive value for general-purpose pin A |
| pin_a_oe | output | 1 | Output-enable for pin A |
| pin_b_out | output | 1 | Drive value for general-purpose pin B |
| pin_b_oe | output | 1 | Output-enable for pin B |

## Verification
Every result is due one clock edge after its stimulus. A strobe or a control write driven before an edge shows on the pins right after that edge, and the pulse stays active for PULSE_LEN more edges. The bench drives its inputs on the falling edge. On each later falling edge it compares all four outputs with a behavioural model that was stepped on the rising edge between. Pulse width, retriggered width and duty fraction are counted from those same falling-edge samples.

// File: rtl/drdy_pulse_gen.sv
module drdy_pulse_gen #(
  parameter int CTRL_W        = 16,
  parameter int UPDATE_PERIOD = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_strobe,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic              pin_a_out,
  output logic              pin_a_oe,
  output logic              pin_b_out,
  output logic              pin_b_oe
);

  localparam int PULSE_LEN = (UPDATE_PERIOD / 4 < 1) ? 1 : UPDATE_PERIOD / 4;
  localparam int CNT_W     = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_LEN);
  localparam int EN_BIT  = 2;
  localparam int POL_BIT = 1;
  localparam int SEL_BIT = 0;

  logic             en_q, pol_q, sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic             active, level;
  logic             unused_hi_bits;

  assign unused_hi_bits = ^ctrl_wdata[CTRL_W-1:EN_BIT+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      pol_q <= 1'b0;
      sel_q <= 1'b0;
    end else if (ctrl_wr) begin
      en_q  <= ctrl_wdata[EN_BIT];
      pol_q <= ctrl_wdata[POL_BIT];
      sel_q <= ctrl_wdata[SEL_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en_q)
      cnt_q <= '0;
    else if (upd_strobe)
      cnt_q <= LOAD;
    else if (active)
      cnt_q <= cnt_q - 1'b1;
  end

  assign active    = (cnt_q != '0);
  assign level     = active ? pol_q : ~pol_q;
  assign pin_a_oe  = en_q & ~sel_q;
  assign pin_b_oe  = en_q &  sel_q;
  assign pin_a_out = pin_a_oe & level;
  assign pin_b_out = pin_b_oe & level;

  AST_ONE_PIN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !(pin_a_oe && pin_b_oe)); // R4
  AST_OFF_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !ctrl_wdata[EN_BIT]) |=> (!pin_a_oe && !pin_b_oe)); // R2
  AST_STROBE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && upd_strobe && !ctrl_wr) |=> (cnt_q == LOAD)); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD); // R6
  AST_DECAY: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && active && !upd_strobe) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R7
  AST_IDLE_AFTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !active); // R8

endmodule

// File: tb/drdy_pulse_gen_bench.sv
`timescale 1ns/1ps
module drdy_pulse_gen_bench;
  localparam int PERIOD = 40;
  localparam int L = (PERIOD / 4 < 1) ? 1 : PERIOD / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_strobe = 1'b0;
  logic ctrl_wr = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic pin_a_out, pin_a_oe, pin_b_out, pin_b_oe;

  int checks = 0;
  int fails = 0;
  int m_ctrl = 0;
  int m_cnt = 0;
  int seen = 0;
  int total = 0;
  bit probe_lvl = 1'b1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  drdy_pulse_gen #(.CTRL_W(16), .UPDATE_PERIOD(PERIOD)) u_drdy_pulse_gen (
    .clk(clk), .rst_n(rst_n), .upd_strobe(upd_strobe), .ctrl_wr(ctrl_wr),
    .ctrl_wdata(ctrl_wdata), .pin_a_out(pin_a_out), .pin_a_oe(pin_a_oe),
    .pin_b_out(pin_b_out), .pin_b_oe(pin_b_oe));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0;
      m_cnt = 0;
    end else begin
      if (((m_ctrl >> 2) & 1) == 0) m_cnt = 0;
      else if (upd_strobe) m_cnt = L;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (ctrl_wr) m_ctrl = int'(ctrl_wdata);
    end
  end

  task automatic check(input string tag, input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    bit en, pol, sel, lvl;
    int exp, act;
    en  = ((m_ctrl >> 2) & 1) != 0;
    pol = ((m_ctrl >> 1) & 1) != 0;
    sel = (m_ctrl & 1) != 0;
    lvl = (m_cnt > 0) ? pol : !pol;
    exp = {en && !sel, (en && !sel) ? lvl : 1'b0, en && sel, (en && sel) ? lvl : 1'b0};
    act = {pin_a_oe, pin_a_out, pin_b_oe, pin_b_out};
    check(tag, act == exp, "pins{a_oe,a,b_oe,b}", act, exp);
  endtask

  task automatic cyc(input string tag, input bit s, input bit w, input logic [15:0] d);
    @(negedge clk);
    compare(tag);
    total++;
    if ((pin_a_oe && pin_a_out == probe_lvl) || (pin_b_oe && pin_b_out == probe_lvl)) seen++;
    upd_strobe = s;
    ctrl_wr = w;
    ctrl_wdata = d;
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 1'b0, 1'b0, 16'h0);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    idle("R1", 3);
    check("R1", {pin_a_oe, pin_b_oe, pin_a_out, pin_b_out} == 4'b0, "reset pins", 0, 0);

    cyc("R2", 1'b1, 1'b0, 16'h0);
    idle("R2", 4);
    cyc("R2", 1'b0, 1'b1, 16'hFFF9);
    cyc("R2", 1'b1, 1'b0, 16'h0);
    idle("R2", 4);
    check("R2", !pin_a_oe && !pin_b_oe, "released while off", int'(pin_a_oe), 0);

    cyc("R8", 1'b0, 1'b1, 16'h0006);
    idle("R8", 2);
    probe_lvl = 1'b1; seen = 0;
    cyc("R5", 1'b1, 1'b0, 16'h0);
    idle("R5", L + 6);
    check("R5", seen == L, "pulse width", seen, L);

    seen = 0;
    cyc("R7", 1'b1, 1'b0, 16'h0);
    idle("R7", 4);
    cyc("R7", 1'b1, 1'b0, 16'h0);
    idle("R7", L + 6);
    check("R7", seen == 5 + L, "retriggered width", seen, 5 + L);

    cyc("R4", 1'b0, 1'b1, 16'h0007);
    idle("R4", 2);
    seen = 0;
    cyc("R4", 1'b1, 1'b0, 16'h0);
    idle("R4", L + 3);
    check("R4", seen == L && !pin_a_oe, "pulse on pin B", seen, L);

    cyc("R3", 1'b0, 1'b1, 16'h0005);
    idle("R3", 2);
    check("R3", pin_b_out == 1'b1, "active-low idle level", int'(pin_b_out), 1);
    probe_lvl = 1'b0; seen = 0;
    cyc("R3", 1'b1, 1'b0, 16'h0);
    idle("R3", L + 3);
    check("R3", seen == L, "active-low width", seen, L);

    cyc("R6", 1'b0, 1'b1, 16'h0004);
    idle("R6", 2);
    seen = 0; total = 0;
    for (int p = 0; p < 4; p++) begin
      cyc("R6", 1'b1, 1'b0, 16'h0);
      idle("R6", PERIOD - 1);
    end
    check("R6", seen * 100 >= 15 * total && seen * 100 <= 35 * total, "duty active cycles", seen, total / 4);

    cyc("R8", 1'b0, 1'b1, 16'h0006);
    cyc("R8", 1'b1, 1'b0, 16'h0);
    idle("R8", 2);
    cyc("R8", 1'b0, 1'b1, 16'h0002);
    idle("R8", 2);
    cyc("R8", 1'b0, 1'b1, 16'h0006);
    idle("R8", 1);
    check("R8", pin_a_oe && pin_a_out == 1'b0, "idle after re-enable", int'(pin_a_out), 0);
    idle("R8", L + 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule